// File: doc/BRIEF.md
# Tiled Minimum/Maximum Statistics Collector

This block watches a raster stream of log-domain wide-dynamic-range pixels, one pixel per clock, and works out which tile of a programmable grid each pixel falls into. For every tile it keeps the smallest and the largest value seen during the frame. The grid geometry comes from four configuration inputs: image width, image height, tile width and tile height. The block samples these at the start of each frame.

When the last pixel of a frame arrives (row height-1, column width-1), the finished per-tile set becomes the published set. A local tone-mapping stage reads that set through a read port addressed by tile row and column during the following frame. Meanwhile the next frame's statistics build up in a second bank. The two banks trade roles on the final pixel, so a reader never sees a half-built set.

Top module: `tile_stats_collector`

## Requirements
- R1: After reset `stats_valid` is 0. Until the first frame has completed, every read returns minimum 16'h0000 and maximum 16'hFFFF. Once `stats_valid` rises it stays 1.
- R2: After a frame completes, a read of tile (row, col) returns the smallest and largest `pix_data` among the valid pixels of that frame whose position maps to that tile. Tile column is pixel column / tile width and tile row is pixel row / tile height, both rounded down and saturated at the last grid index.
- R3: The first valid pixel that a frame places in a tile sets both that tile's minimum and maximum to its value. Nothing left over from an older frame takes part in the comparison.
- R4: When the width or height is not a multiple of the tile size, the leftover columns or rows form a tile of their own with the next tile index.
- R5: A cycle with `pix_valid` low has no effect, whatever `pix_data`, `pix_sof` and `pix_eol` carry. It does not advance the position and does not touch any statistic.
- R6: A valid pixel with `pix_sof` high is placed at row 0, column 0 and starts a fresh frame. A frame cut short by a new `pix_sof` is discarded and is never published. A valid pixel with `pix_eol` high is the last of its row, and the next valid pixel goes to column 0 of the next row.
- R7: The published set changes only on the clock edge that takes the final pixel of a frame. Reads made while a frame is being collected return the previous completed frame.
- R8: The read port has one clock of latency. `rd_min`/`rd_max` reflect the tile address presented before the preceding rising edge.
- R9: A grid tile that received no pixel in the last completed frame reads back minimum 16'h0000 and maximum 16'hFFFF.
- R10: The configuration inputs are sampled on the start-of-frame pixel. Changes during a frame do not affect that frame's tiling or its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a row |
| pix_data | input | PIX_W | Log-domain pixel value |
| cfg_width | input | 12 | Image width in pixels |
| cfg_height | input | 12 | Image height in rows |
| cfg_tile_w | input | 12 | Tile width in pixels |
| cfg_tile_h | input | 12 | Tile height in rows |
| rd_tile_col | input | TC_W | Read address, tile column |
| rd_tile_row | input | TR_W | Read address, tile row |
| rd_min | output | PIX_W | Published minimum of the addressed tile |
| rd_max | output | PIX_W | Published maximum of the addressed tile |
| stats_valid | output | 1 | A complete frame has been published |

## Verification
A position counter that drifts, for example one stepped by an idle cycle or not cleared on `pix_eol`, sends pixels into the wrong tile. It shows up only as wrong minima or maxima once the frame is published, one read cycle after the address is given. A stale accumulator or a missing first-pixel load shows as a minimum that is too low or a maximum that is too high in the frame after the one that polluted the bank. A bad bank swap shows during the next frame as mid-frame reads that differ from the last published frame. Each frame is therefore read back across the whole grid and also sampled partway through the following frame.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // width of every geometry field on the configuration inputs
  localparam int CFG_W = 12;

  typedef struct packed {
    logic [CFG_W-1:0] width;
    logic [CFG_W-1:0] height;
    logic [CFG_W-1:0] tile_w;
    logic [CFG_W-1:0] tile_h;
  } tsc_cfg_t;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tsc_raster_track.sv
module tsc_raster_track
  import tsc_pkg::*;
#(
  parameter int GRID_COLS = 4,
  parameter int GRID_ROWS = 4,
  parameter int TC_W      = 2,
  parameter int TR_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  tsc_cfg_t         cfg_in,
  output logic [TC_W-1:0]  tile_col,
  output logic [TR_W-1:0]  tile_row,
  output logic             frame_end,
  output logic [CFG_W-1:0] col_q
);
  localparam logic [CFG_W-1:0] ONE     = CFG_W'(1);
  localparam logic [TC_W-1:0]  TC_LAST = TC_W'(GRID_COLS - 1);
  localparam logic [TR_W-1:0]  TR_LAST = TR_W'(GRID_ROWS - 1);
  localparam logic [TC_W-1:0]  TC_ONE  = TC_W'(1);
  localparam logic [TR_W-1:0]  TR_ONE  = TR_W'(1);

  tsc_cfg_t         cfg_q, cfg_eff;
  logic [CFG_W-1:0] row_q, scol_q, srow_q;
  logic [CFG_W-1:0] col_c, row_c, scol_c, srow_c;
  logic [TC_W-1:0]  tcol_q, tcol_c;
  logic [TR_W-1:0]  trow_q, trow_c;

  // position of the pixel on the inputs now (start of frame forces origin)
  always_comb begin
    if (in_sof) begin
      cfg_eff = cfg_in;
      col_c   = '0;
      row_c   = '0;
      scol_c  = '0;
      srow_c  = '0;
      tcol_c  = '0;
      trow_c  = '0;
    end else begin
      cfg_eff = cfg_q;
      col_c   = col_q;
      row_c   = row_q;
      scol_c  = scol_q;
      srow_c  = srow_q;
      tcol_c  = tcol_q;
      trow_c  = trow_q;
    end
  end

  assign tile_col  = tcol_c;
  assign tile_row  = trow_c;
  assign frame_end = in_valid && (row_c == cfg_eff.height - ONE) &&
                     (col_c == cfg_eff.width - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      col_q  <= '0;
      row_q  <= '0;
      scol_q <= '0;
      srow_q <= '0;
      tcol_q <= '0;
      trow_q <= '0;
    end else if (in_valid) begin
      cfg_q <= cfg_eff;
      if (in_eol) begin
        col_q  <= '0;
        scol_q <= '0;
        tcol_q <= '0;
        row_q  <= row_c + ONE;
        if (srow_c == cfg_eff.tile_h - ONE) begin
          srow_q <= '0;
          trow_q <= (trow_c == TR_LAST) ? trow_c : trow_c + TR_ONE;
        end else begin
          srow_q <= srow_c + ONE;
          trow_q <= trow_c;
        end
      end else begin
        col_q  <= col_c + ONE;
        row_q  <= row_c;
        srow_q <= srow_c;
        trow_q <= trow_c;
        if (scol_c == cfg_eff.tile_w - ONE) begin
          scol_q <= '0;
          tcol_q <= (tcol_c == TC_LAST) ? tcol_c : tcol_c + TC_ONE;
        end else begin
          scol_q <= scol_c + ONE;
          tcol_q <= tcol_c;
        end
      end
    end
  end
endmodule

// File: rtl/tsc_minmax_merge.sv
module tsc_minmax_merge #(
  parameter int PIX_W = 16
) (
  input  logic [PIX_W-1:0] old_lo,
  input  logic [PIX_W-1:0] old_hi,
  input  logic             old_hit,
  input  logic [PIX_W-1:0] px,
  output logic [PIX_W-1:0] new_lo,
  output logic [PIX_W-1:0] new_hi
);
  always_comb begin
    if (!old_hit) begin
      new_lo = px;
      new_hi = px;
    end else begin
      new_lo = (px < old_lo) ? px : old_lo;
      new_hi = (px > old_hi) ? px : old_hi;
    end
  end
endmodule

// File: rtl/tsc_tile_bank.sv
module tsc_tile_bank #(
  parameter int PIX_W     = 16,
  parameter int GRID_COLS = 4,
  parameter int GRID_ROWS = 4,
  parameter int TC_W      = 2,
  parameter int TR_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             px_fire,
  input  logic             px_sof,
  input  logic [PIX_W-1:0] px_data,
  input  logic [TC_W-1:0]  px_col,
  input  logic [TR_W-1:0]  px_row,
  input  logic             frame_end,
  input  logic [TC_W-1:0]  rd_col,
  input  logic [TR_W-1:0]  rd_row,
  output logic [PIX_W-1:0] rd_min,
  output logic [PIX_W-1:0] rd_max,
  output logic             stats_valid
);
  localparam int NT    = GRID_COLS * GRID_ROWS;
  localparam int IDX_W = tsc_pkg::idx_bits(NT);

  logic [PIX_W-1:0] lo_mem [2][NT];
  logic [PIX_W-1:0] hi_mem [2][NT];
  logic [NT-1:0]    hit_q  [2];
  logic             pub_sel, acc_sel;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [PIX_W-1:0] new_lo, new_hi;
  logic             old_hit, rd_ok;

  assign acc_sel = ~pub_sel;
  assign wr_idx  = IDX_W'(px_row) * IDX_W'(GRID_COLS) + IDX_W'(px_col);
  assign rd_idx  = IDX_W'(rd_row) * IDX_W'(GRID_COLS) + IDX_W'(rd_col);
  assign rd_ok   = ({1'b0, rd_col} < (TC_W+1)'(GRID_COLS)) &&
                   ({1'b0, rd_row} < (TR_W+1)'(GRID_ROWS));
  // a start-of-frame pixel never merges with what the bank held before
  assign old_hit = hit_q[acc_sel][wr_idx] && !px_sof;

  tsc_minmax_merge #(.PIX_W(PIX_W)) u_merge (
    .old_lo  (lo_mem[acc_sel][wr_idx]),
    .old_hi  (hi_mem[acc_sel][wr_idx]),
    .old_hit (old_hit),
    .px      (px_data),
    .new_lo  (new_lo),
    .new_hi  (new_hi)
  );

  // statistic storage: plain write port, no reset
  always_ff @(posedge clk) begin
    if (px_fire) begin
      lo_mem[acc_sel][wr_idx] <= new_lo;
      hi_mem[acc_sel][wr_idx] <= new_hi;
    end
  end

  // occupancy flags and bank ownership
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q[0]    <= '0;
      hit_q[1]    <= '0;
      pub_sel     <= 1'b0;
      stats_valid <= 1'b0;
    end else begin
      if (px_fire && px_sof) hit_q[acc_sel] <= '0;
      if (px_fire) hit_q[acc_sel][wr_idx] <= 1'b1;
      if (frame_end) begin
        pub_sel     <= acc_sel;
        stats_valid <= 1'b1;
      end
    end
  end

  // registered read port on the published bank
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_min <= '0;
      rd_max <= '1;
    end else if (stats_valid && rd_ok && hit_q[pub_sel][rd_idx]) begin
      rd_min <= lo_mem[pub_sel][rd_idx];
      rd_max <= hi_mem[pub_sel][rd_idx];
    end else begin
      rd_min <= '0;
      rd_max <= '1;
    end
  end
endmodule

// File: rtl/tile_stats_collector.sv
module tile_stats_collector
  import tsc_pkg::*;
#(
  parameter  int PIX_W     = 16,
  parameter  int GRID_COLS = 4,
  parameter  int GRID_ROWS = 4,
  localparam int TC_W      = tsc_pkg::idx_bits(GRID_COLS),
  localparam int TR_W      = tsc_pkg::idx_bits(GRID_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic             pix_eol,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [CFG_W-1:0] cfg_width,
  input  logic [CFG_W-1:0] cfg_height,
  input  logic [CFG_W-1:0] cfg_tile_w,
  input  logic [CFG_W-1:0] cfg_tile_h,
  input  logic [TC_W-1:0]  rd_tile_col,
  input  logic [TR_W-1:0]  rd_tile_row,
  output logic [PIX_W-1:0] rd_min,
  output logic [PIX_W-1:0] rd_max,
  output logic             stats_valid
);
  tsc_cfg_t         cfg_bus;
  logic [TC_W-1:0]  cur_tcol;
  logic [TR_W-1:0]  cur_trow;
  logic             frame_end;
  logic [CFG_W-1:0] trk_col;

  assign cfg_bus = '{width: cfg_width, height: cfg_height,
                     tile_w: cfg_tile_w, tile_h: cfg_tile_h};

  tsc_raster_track #(
    .GRID_COLS (GRID_COLS),
    .GRID_ROWS (GRID_ROWS),
    .TC_W      (TC_W),
    .TR_W      (TR_W)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (pix_valid),
    .in_sof    (pix_sof),
    .in_eol    (pix_eol),
    .cfg_in    (cfg_bus),
    .tile_col  (cur_tcol),
    .tile_row  (cur_trow),
    .frame_end (frame_end),
    .col_q     (trk_col)
  );

  tsc_tile_bank #(
    .PIX_W     (PIX_W),
    .GRID_COLS (GRID_COLS),
    .GRID_ROWS (GRID_ROWS),
    .TC_W      (TC_W),
    .TR_W      (TR_W)
  ) u_bank (
    .clk         (clk),
    .rst         (rst),
    .px_fire     (pix_valid),
    .px_sof      (pix_sof),
    .px_data     (pix_data),
    .px_col      (cur_tcol),
    .px_row      (cur_trow),
    .frame_end   (frame_end),
    .rd_col      (rd_tile_col),
    .rd_row      (rd_tile_row),
    .rd_min      (rd_min),
    .rd_max      (rd_max),
    .stats_valid (stats_valid)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int PIX_W = 16,
  parameter int CW    = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic             pix_sof,
  input logic             pix_eol,
  input logic             frame_end,
  input logic [CW-1:0]    col_q,
  input logic             stats_valid,
  input logic [PIX_W-1:0] rd_min,
  input logic [PIX_W-1:0] rd_max
);
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    stats_valid |=> stats_valid); // R1
  AST_DEFAULT_BEFORE_FIRST: assert property (@(posedge clk) disable iff (rst)
    !stats_valid |=> (rd_min == '0 && rd_max == '1)); // R1
  AST_READ_ORDERED: assert property (@(posedge clk) disable iff (rst)
    rd_min <= rd_max); // R2
  AST_IDLE_HOLDS_POS: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> $stable(col_q)); // R5
  AST_END_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> pix_valid); // R5
  AST_EOL_RESTARTS_COL: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_eol) |=> (col_q == '0)); // R6
  AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_sof && !pix_eol) |=> (col_q == CW'(1))); // R6
  AST_PUBLISH_ON_END: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> stats_valid); // R7
endmodule

bind tile_stats_collector tsc_checker #(.PIX_W(PIX_W), .CW(tsc_pkg::CFG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pix_valid   (pix_valid),
  .pix_sof     (pix_sof),
  .pix_eol     (pix_eol),
  .frame_end   (frame_end),
  .col_q       (trk_col),
  .stats_valid (stats_valid),
  .rd_min      (rd_min),
  .rd_max      (rd_max)
);

// File: tb/tile_stats_collector_bench.sv
module tile_stats_collector_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_valid = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
  logic [15:0] pix_data = '0;
  logic [11:0] cfg_width = '0, cfg_height = '0, cfg_tile_w = '0, cfg_tile_h = '0;
  logic [1:0]  rd_tile_col = '0, rd_tile_row = '0;
  logic [15:0] rd_min, rd_max;
  logic        stats_valid;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] pub_lo [16], pub_hi [16], acc_lo [16], acc_hi [16];
  bit          pub_hit [16], acc_hit [16];

  always #2 clk = ~clk;

  tile_stats_collector u_tile_stats_collector (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_eol(pix_eol), .pix_data(pix_data), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_tile_w(cfg_tile_w), .cfg_tile_h(cfg_tile_h),
    .rd_tile_col(rd_tile_col), .rd_tile_row(rd_tile_row),
    .rd_min(rd_min), .rd_max(rd_max), .stats_valid(stats_valid)
  );

  task automatic chk(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic chk_pair(input string req, input logic [15:0] lo, input logic [15:0] hi,
                          input logic [15:0] elo, input logic [15:0] ehi);
    chk(lo === elo && hi === ehi, req,
        $sformatf("actual min=%h max=%h expected min=%h max=%h", lo, hi, elo, ehi));
  endtask

  function automatic logic [15:0] pv(input int seed, input int r, input int c);
    if (seed == 0) return 16'h5A5A;
    return 16'((seed * 4099 + r * 523 + c * 197 + r * c * 31) * 13);
  endfunction

  function automatic int tix(input int r, input int c, input int tw, input int th);
    int tc = c / tw;
    int tr = r / th;
    if (tc > 3) tc = 3;
    if (tr > 3) tr = 3;
    return tr * 4 + tc;
  endfunction

  task automatic read_tile(input int r, input int c, output logic [15:0] lo, output logic [15:0] hi);
    rd_tile_row = 2'(r);
    rd_tile_col = 2'(c);
    @(negedge clk);
    lo = rd_min;
    hi = rd_max;
  endtask

  // reads the whole grid and compares with the last completed frame (R2, R8)
  task automatic check_all(input string req);
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        logic [15:0] lo, hi;
        int i = r * 4 + c;
        read_tile(r, c, lo, hi);
        if (pub_hit[i]) chk_pair($sformatf("%s R8 tile(%0d,%0d)", req, r, c), lo, hi, pub_lo[i], pub_hi[i]);
        else chk_pair($sformatf("%s R9 tile(%0d,%0d)", req, r, c), lo, hi, 16'h0000, 16'hFFFF);
      end
    end
  endtask

  task automatic send_frame(input int seed, input int w, input int h, input int tw, input int th,
                            input bit gaps, input bit mid_cfg, input int abort_at, input bit mid_read);
    int n = 0;
    for (int i = 0; i < 16; i++) acc_hit[i] = 0;
    cfg_width = 12'(w); cfg_height = 12'(h); cfg_tile_w = 12'(tw); cfg_tile_h = 12'(th);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        int i = tix(r, c, tw, th);
        logic [15:0] v = pv(seed, r, c);
        if (abort_at > 0 && n == abort_at) begin
          pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
          return;
        end
        if (abort_at > 0) v = (n % 2 == 1) ? 16'h0000 : 16'hFFFF;
        pix_valid = 1'b1; pix_sof = (r == 0 && c == 0); pix_eol = (c == w - 1); pix_data = v;
        if (mid_read && n == 5) begin rd_tile_row = 2'd0; rd_tile_col = 2'd0; end
        @(negedge clk);
        if (mid_cfg && n == 0) begin
          cfg_width = 12'd3; cfg_height = 12'd2; cfg_tile_w = 12'd1; cfg_tile_h = 12'd1;
        end
        if (mid_read && n == 5) begin
          if (pub_hit[0]) chk_pair("R7 mid-frame read", rd_min, rd_max, pub_lo[0], pub_hi[0]);
          else chk_pair("R7 mid-frame read before first frame", rd_min, rd_max, 16'h0000, 16'hFFFF);
        end
        if (!acc_hit[i]) begin acc_lo[i] = v; acc_hi[i] = v; acc_hit[i] = 1; end
        else begin
          if (v < acc_lo[i]) acc_lo[i] = v;
          if (v > acc_hi[i]) acc_hi[i] = v;
        end
        if (gaps) begin
          // R5: idle cycle carrying markers and extreme data
          pix_valid = 1'b0; pix_sof = 1'b1; pix_eol = 1'b1;
          pix_data = (n % 2 == 1) ? 16'h0000 : 16'hFFFF;
          @(negedge clk);
        end
        n++;
      end
    end
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pub_hit[i] = acc_hit[i]; pub_lo[i] = acc_lo[i]; pub_hi[i] = acc_hi[i];
    end
  endtask

  task automatic t_reset;
    logic [15:0] lo, hi;
    chk(stats_valid === 1'b0, "R1", $sformatf("stats_valid actual %b expected 0", stats_valid));
    read_tile(0, 0, lo, hi);
    chk_pair("R1 default tile(0,0)", lo, hi, 16'h0000, 16'hFFFF);
    read_tile(3, 3, lo, hi);
    chk_pair("R1 default tile(3,3)", lo, hi, 16'h0000, 16'hFFFF);
  endtask

  // 8x6 with 3x2 tiles: partial last column tile (R4), idle gaps (R5)
  task automatic t_partial_tiles;
    send_frame(1, 8, 6, 3, 2, 1'b1, 1'b0, 0, 1'b1);
    chk(stats_valid === 1'b1, "R1", $sformatf("stats_valid actual %b expected 1", stats_valid));
    check_all("R2 R4 R5");
  endtask

  // 7x5 with 2x2 tiles, config disturbed after start of frame (R10)
  task automatic t_cfg_latched;
    send_frame(2, 7, 5, 2, 2, 1'b0, 1'b1, 0, 1'b0);
    check_all("R10 R4");
  endtask

  // constant frame into the bank holding an older spread-out frame (R3)
  task automatic t_first_load;
    send_frame(0, 8, 8, 2, 2, 1'b0, 1'b0, 0, 1'b0);
    check_all("R3");
  endtask

  // aborted frame then a full frame (R6), with a read during collection (R7)
  task automatic t_abort_restart;
    send_frame(9, 8, 8, 2, 2, 1'b0, 1'b0, 10, 1'b0);
    @(negedge clk);
    send_frame(3, 8, 8, 3, 3, 1'b0, 1'b0, 0, 1'b1);
    check_all("R6");
  endtask

  // output follows the address one edge late (R8)
  task automatic t_latency;
    logic [15:0] lo, hi;
    read_tile(0, 0, lo, hi);
    rd_tile_row = 2'd2; rd_tile_col = 2'd2;
    #1;
    chk_pair("R8 before edge", rd_min, rd_max, pub_lo[0], pub_hi[0]);
    @(negedge clk);
    chk_pair("R8 after edge", rd_min, rd_max, pub_lo[10], pub_hi[10]);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_partial_tiles();
    t_cfg_latched();
    t_first_load();
    t_abort_restart();
    t_latency();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule